// File: doc/BRIEF.md
# Interrupt Priority Level Assignment Unit

This block stores a programmable priority level for each interrupt source of a small controller. It then picks the most urgent pending request. Five 16-bit registers sit on a plain register bus. Each register is split into four 4-bit level fields. Eight external request lines each own a field. The on-chip sources (four DMA channels, five timers, two serial ports, a parity checker, an ADC, a watchdog and a DRAM refresh engine) take the remaining fields, and some of them share a field in pairs.

On every cycle, each request is paired with the level of its field. The unit registers the highest pending level and the identifier of the source that won. It also raises an interrupt request toward the CPU when that level is above the CPU's current 4-bit mask. A standby input freezes the register bank so that its contents survive a low-power period. Only a true reset clears the registers.

Top module: `ipl_unit`

## Requirements
- R1: After reset, all five registers read 0x0000, and irq_valid_o, irq_level_o, irq_src_o and irq_req_o are all 0.
- R2: A write with we_i high and addr_i in 0..4 stores wdata_i into that register. rdata_o shows the register selected by addr_i in the same cycle, with no clock delay. For addr_i 5..7, rdata_o reads 0 and writes change nothing.
- R3: Field slot k of a register (k = 0..3) occupies bits [15-4k:12-4k]. External line n (source id n, 0..7) uses register n/4, slot n%4.
- R4: On-chip source ids and their fields are as follows. DMA0/DMA1 (ids 8, 9) share register 2 slot 0. DMA2/DMA3 (10, 11) share register 2 slot 1. Timer0 (12) uses register 2 slot 2 and timer1 (13) register 2 slot 3. Timers 2–4 (14–16) use register 3 slots 0–2. Serial0 (17) uses register 3 slot 3 and serial1 (18) register 4 slot 0. Parity/ADC (19, 20) share register 4 slot 1. Watchdog/refresh (21, 22) share register 4 slot 2. Sources that share a field always get the same level.
- R5: Register 4 slot 3 (bits 3:0) is reserved. It always reads 0, and writing to it has no effect.
- R6: A requesting source whose level is 0 is never reported as pending. If no source is pending, irq_valid_o is 0 and irq_level_o and irq_src_o are 0.
- R7: When at least one source is pending, irq_valid_o is 1. irq_level_o is the highest level among the pending sources, and irq_src_o is the id of the winning source.
- R8: When several pending sources share the highest level, the one with the lowest id wins.
- R9: irq_req_o is 1 exactly when a source is pending and its winning level is strictly greater than mask_i.
- R10: The outputs are registered. A change in requests, mask or register contents shows up on the outputs after the next rising clock edge.
- R11: While standby_i is high, register writes are ignored and the stored levels are kept. Only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low true reset |
| addr_i | input | 3 | Register word address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Combinational read data |
| standby_i | input | 1 | Standby: freezes the register bank |
| src_req_i | input | 23 | Request lines, indexed by source id |
| mask_i | input | 4 | CPU interrupt mask level |
| irq_valid_o | output | 1 | A source with a nonzero level is pending |
| irq_level_o | output | 4 | Winning level |
| irq_src_o | output | 5 | Winning source id |
| irq_req_o | output | 1 | Interrupt request to the CPU |

## Verification
The hardest case to reach is a tie at the top level in which the contenders differ only in their id. This includes the two halves of a shared field, whose levels can never differ. Uniform random levels and requests seldom produce it. The stimulus therefore keeps the programmed levels within a narrow random band, so that ties happen often. It also adds directed cases that raise both members of a shared pair, and cases that set mask_i equal to the winning level.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int FIELD_W    = 4;
  localparam int SLOTS      = 4;
  localparam int REG_W      = FIELD_W * SLOTS;
  localparam int NUM_REGS   = 5;
  localparam int NUM_FIELDS = NUM_REGS * SLOTS;
  localparam int RSV_FIELD  = NUM_FIELDS - 1;
  localparam int NUM_EXT    = 8;
  localparam int NUM_DMA    = 4;
  localparam int NUM_SOLO   = 7;
  localparam int NUM_PAIRED = 4;
  localparam int NUM_SRC    = NUM_EXT + NUM_DMA + NUM_SOLO + NUM_PAIRED;
  localparam int SRC_W      = $clog2(NUM_SRC);
  localparam int ADDR_W     = 3;

  typedef struct packed {
    logic               valid;
    logic [FIELD_W-1:0] level;
    logic [SRC_W-1:0]   src;
  } win_t;

  // Map a source id onto the flat field index (register * SLOTS + slot).
  function automatic int src_to_field(input int id);
    if (id < NUM_EXT)                          return id;
    if (id < NUM_EXT + NUM_DMA)                return NUM_EXT + (id - NUM_EXT) / 2;
    if (id < NUM_EXT + NUM_DMA + NUM_SOLO)     return id - NUM_DMA / 2;
    return NUM_EXT + NUM_DMA / 2 + NUM_SOLO + (id - NUM_EXT - NUM_DMA - NUM_SOLO) / 2;
  endfunction
endpackage

// File: rtl/ipl_regbank.sv
module ipl_regbank
  import ipl_pkg::*;
(
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [REG_W-1:0]              wdata_i,
  input  logic                          standby_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [NUM_FIELDS*FIELD_W-1:0] fields_o
);
  logic wr_ok;
  assign wr_ok = we_i && !standby_i;

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int REG  = f / SLOTS;
    localparam int SLOT = f % SLOTS;
    localparam int LSB  = REG_W - FIELD_W * (SLOT + 1);
    if (f == RSV_FIELD) begin : g_rsv
      assign fields_o[f*FIELD_W +: FIELD_W] = '0;
    end else begin : g_rw
      logic [FIELD_W-1:0] lvl_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          lvl_q <= '0;
        else if (wr_ok && addr_i == ADDR_W'(REG))
          lvl_q <= wdata_i[LSB +: FIELD_W];
      end
      assign fields_o[f*FIELD_W +: FIELD_W] = lvl_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (addr_i == ADDR_W'(r)) begin
        for (int k = 0; k < SLOTS; k++)
          rdata_o[REG_W - FIELD_W*(k+1) +: FIELD_W] = fields_o[(r*SLOTS + k)*FIELD_W +: FIELD_W];
      end
    end
  end
endmodule

// File: rtl/ipl_srcmap.sv
module ipl_srcmap
  import ipl_pkg::*;
(
  input  logic [NUM_FIELDS*FIELD_W-1:0] fields_i,
  input  logic [NUM_SRC-1:0]            req_i,
  output logic [NUM_SRC*FIELD_W-1:0]    lvl_o,
  output logic [NUM_SRC-1:0]            pend_o
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    localparam int FLD = src_to_field(s);
    assign lvl_o[s*FIELD_W +: FIELD_W] = fields_i[FLD*FIELD_W +: FIELD_W];
    assign pend_o[s] = req_i[s] && (fields_i[FLD*FIELD_W +: FIELD_W] != '0);
  end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
  import ipl_pkg::*;
(
  input  logic [NUM_SRC*FIELD_W-1:0] lvl_i,
  input  logic [NUM_SRC-1:0]         pend_i,
  output win_t                       win_o
);
  always_comb begin
    win_o = '0;
    // Scan from the highest id down; ">=" lets a lower id take ties.
    for (int s = NUM_SRC - 1; s >= 0; s--) begin
      if (pend_i[s] && lvl_i[s*FIELD_W +: FIELD_W] >= win_o.level) begin
        win_o.valid = 1'b1;
        win_o.level = lvl_i[s*FIELD_W +: FIELD_W];
        win_o.src   = SRC_W'(s);
      end
    end
  end
endmodule

// File: rtl/ipl_unit.sv
module ipl_unit
  import ipl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  input  logic                standby_i,
  input  logic [NUM_SRC-1:0]  src_req_i,
  input  logic [FIELD_W-1:0]  mask_i,
  output logic                irq_valid_o,
  output logic [FIELD_W-1:0]  irq_level_o,
  output logic [SRC_W-1:0]    irq_src_o,
  output logic                irq_req_o
);
  logic [NUM_FIELDS*FIELD_W-1:0] fields;
  logic [NUM_SRC*FIELD_W-1:0]    lvl;
  logic [NUM_SRC-1:0]            pend;
  win_t                          win_d, win_q;
  logic                          req_q;

  ipl_regbank u_bank (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .standby_i,
    .rdata_o, .fields_o(fields)
  );

  ipl_srcmap u_map (
    .fields_i(fields), .req_i(src_req_i), .lvl_o(lvl), .pend_o(pend)
  );

  ipl_arbiter u_arb (
    .lvl_i(lvl), .pend_i(pend), .win_o(win_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      req_q <= 1'b0;
    end else begin
      win_q <= win_d;
      req_q <= win_d.valid && (win_d.level > mask_i);
    end
  end

  assign irq_valid_o = win_q.valid;
  assign irq_level_o = win_q.level;
  assign irq_src_o   = win_q.src;
  assign irq_req_o   = req_q;
endmodule

// File: rtl/ipl_checker.sv
module ipl_checker
  import ipl_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [REG_W-1:0]   rdata_o,
  input logic               standby_i,
  input logic [FIELD_W-1:0] mask_i,
  input logic               irq_valid_o,
  input logic [FIELD_W-1:0] irq_level_o,
  input logic [SRC_W-1:0]   irq_src_o,
  input logic               irq_req_o
);
  AST_RSV_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(NUM_REGS - 1)) |-> (rdata_o[FIELD_W-1:0] == '0)); // R5

  AST_HIGH_ADDR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i >= ADDR_W'(NUM_REGS)) |-> (rdata_o == '0)); // R2

  AST_NO_ZERO_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_valid_o |-> (irq_level_o != '0)); // R6

  AST_IDLE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_valid_o |-> (irq_level_o == '0 && irq_src_o == '0)); // R6

  AST_SRC_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_src_o < SRC_W'(NUM_SRC)); // R7

  AST_REQ_ABOVE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_req_o |-> (irq_valid_o && irq_level_o > $past(mask_i))); // R9

  AST_STANDBY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(standby_i) && $stable(addr_i)) |-> $stable(rdata_o)); // R11
endmodule

bind ipl_unit ipl_checker u_chk (
  .clk_i, .rst_ni, .addr_i, .rdata_o, .standby_i, .mask_i,
  .irq_valid_o, .irq_level_o, .irq_src_o, .irq_req_o
);

// File: tb/ipl_unit_tb.sv
module ipl_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        stby = 1'b0;
  logic [22:0] req = '0;
  logic [3:0]  mask = '0;
  logic        vld, irq;
  logic [3:0]  lvl;
  logic [4:0]  src;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] mdl [5];
  logic        e_vld, e_irq;
  logic [3:0]  e_lvl;
  logic [4:0]  e_src;

  always #2 clk = ~clk;

  ipl_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .standby_i(stby), .src_req_i(req), .mask_i(mask),
    .irq_valid_o(vld), .irq_level_o(lvl), .irq_src_o(src), .irq_req_o(irq)
  );

  // Field of each source id, from the table in R3/R4.
  function automatic int fld_of(input int id);
    int t [15] = '{8, 8, 9, 9, 10, 11, 12, 13, 14, 15, 16, 17, 17, 18, 18};
    if (id < 8) return id;
    return t[id - 8];
  endfunction

  function automatic logic [3:0] lvl_of(input int id);
    int f = fld_of(id);
    return mdl[f / 4][15 - 4 * (f % 4) -: 4];
  endfunction

  function automatic void predict(input logic [22:0] r, input logic [3:0] m);
    e_vld = 0; e_lvl = 0; e_src = 0;
    for (int s = 0; s < 23; s++)
      if (r[s] && lvl_of(s) != 0 && lvl_of(s) > e_lvl) begin
        e_vld = 1; e_lvl = lvl_of(s); e_src = 5'(s);
      end
    e_irq = e_vld && (e_lvl > m);
  endfunction

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic check_out(input string rq);
    check({rq, " valid"}, 32'(vld), 32'(e_vld));
    check({rq, " level"}, 32'(lvl), 32'(e_lvl));
    check({rq, " src"},   32'(src), 32'(e_src));
    check({rq, " irq"},   32'(irq), 32'(e_irq));
  endtask

  // One cycle: drive at negedge, model the edge, check registered outputs at the next negedge.
  task automatic step(input logic w, input logic [2:0] a, input logic [15:0] d,
                      input logic [22:0] r, input logic [3:0] m, input logic sb, input string rq);
    we = w; addr = a; wdata = d; req = r; mask = m; stby = sb;
    predict(r, m);
    @(posedge clk);
    if (w && !sb && a < 5) mdl[a] = (a == 4) ? (d & 16'hFFF0) : d;
    @(negedge clk);
    we = 0;
    check_out({rq, " R10"});
    #0.5;
    check({rq, " R2 readback"}, 32'(rdata), (a < 5) ? 32'(mdl[a]) : 32'h0);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    step(1'b1, a, d, '0, 4'hF, 1'b0, "setup");
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1B4D));
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    e_vld = 0; e_lvl = 0; e_src = 0; e_irq = 0;
    check_out("R1");
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a); #0.5;
      check("R1 reg", 32'(rdata), 32'h0);
    end

    // R2: out-of-range writes ignored, reads zero
    step(1'b1, 3'd6, 16'hBEEF, '0, 4'h0, 1'b0, "R2 high addr");
    for (int a = 0; a < 5; a++) begin
      addr = 3'(a); #0.5;
      check("R2 high addr no effect", 32'(rdata), 32'h0);
    end

    // R5: reserved field
    step(1'b1, 3'd4, 16'hFFFF, '0, 4'h0, 1'b0, "R5 reserved write");
    check("R5 reserved bits", 32'(rdata[3:0]), 32'h0);

    // R3: line 0 in top field of register 0, line 3 in bottom field
    wr(3'd0, 16'h1005);
    step(1'b0, 3'd0, 0, 23'h9, 4'h0, 1'b0, "R3 ext slots");
    // R6: level-0 source requesting with nothing else
    wr(3'd1, 16'h0000);
    step(1'b0, 3'd1, 0, 23'hF0, 4'h0, 1'b0, "R6 zero level");

    // R4: shared pair DMA0/1 share a field; both request, lower id wins
    wr(3'd2, 16'h7000);
    step(1'b0, 3'd2, 0, 23'(1) << 9, 4'h0, 1'b0, "R4 dma1 alone");
    step(1'b0, 3'd2, 0, (23'(1) << 9) | (23'(1) << 8), 4'h0, 1'b0, "R4 R8 dma pair");
    wr(3'd4, 16'h0A30);
    step(1'b0, 3'd4, 0, (23'(1) << 22) | (23'(1) << 20), 4'h0, 1'b0, "R4 wdt/ref vs adc");

    // R8: tie between ext line 3 (level 5) and a higher-id source at 5
    wr(3'd3, 16'h0005);
    step(1'b0, 3'd3, 0, (23'(1) << 17) | (23'(1) << 3), 4'h0, 1'b0, "R8 tie");

    // R9: mask equal to level blocks, one lower lets through
    step(1'b0, 3'd0, 0, 23'h1, 4'h1, 1'b0, "R9 mask equal");
    step(1'b0, 3'd0, 0, 23'h8, 4'h4, 1'b0, "R9 mask below");

    // R11: standby blocks writes and keeps contents
    step(1'b1, 3'd0, 16'hFFFF, 23'h1, 4'h0, 1'b1, "R11 standby write");
    step(1'b0, 3'd0, 0, 23'h1, 4'h0, 1'b0, "R11 after standby");

    // Random mix: narrow level band makes ties common (R7, R8, R9, R10)
    for (int it = 0; it < 600; it++) begin
      logic [3:0] base = 4'($urandom_range(0, 13));
      logic [15:0] d;
      for (int k = 0; k < 4; k++) d[4*k +: 4] = base + 4'($urandom_range(0, 2));
      step(($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)), d,
           23'($urandom), 4'($urandom_range(0, 15)), ($urandom_range(0, 9) == 0),
           "R7 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule